// File: doc/BRIEF.md
# Programmable flag offset register file

This block holds the two thresholds that a FIFO's programmable flags compare against: an empty-side offset and a full-side offset. Both are driven out continuously to the flag logic, which lives outside this block. Master reset does two things. It samples the load-select pin to pick a default value, either the small or the large one. It also fixes the programming method for the whole session: parallel words taken from the data bus, or single bits taken from a serial input pin.

After reset, the load-select pin marks offset-register cycles. On the write clock, load-select together with the write enable or the serial enable updates an offset, depending on the method. On the read clock, load-select together with the read enable copies one offset onto the readback bus. Both the loader and the reader step through the empty offset first and then the full offset, and then start again.

Partial reset rewinds the load, serial and readback sequencing and clears the readback bus. It keeps the stored offsets and the programming method, so a running system can be restarted without programming the offsets again. Every pin here is plain control or status: there is no streaming data path, so the block has no valid/ready handshake.

Top module: `ofs_regfile`

## Requirements
- R1: When master reset is high at a write-clock edge and load-select is low, both offsets become 127 and the parallel method is selected.
- R2: When master reset is high at a write-clock edge and load-select is high, both offsets become 1023 and the serial method is selected.
- R3: In parallel mode, a write-clock edge with write enable and load-select high stores din_i[15:0] into one offset. The target alternates: empty first, then full, then empty again. din_i[17:16] are discarded.
- R4: In serial mode, a write-clock edge with serial enable and load-select high writes si_i into a single bit of one offset. The order is bits 0 to 15 of the empty offset, then bits 0 to 15 of the full offset, then back to bit 0 of the empty offset.
- R5: The serial enable has no effect in parallel mode, and the write enable has no effect in serial mode.
- R6: The offsets change only on an active load cycle (R3 or R4) or on master reset. Write or serial enable without load-select leaves them unchanged.
- R7: A read-clock edge with read enable and load-select high puts an offset on rd_data_o, zero-extended so that bits 17:16 are 0. The source alternates empty, full, empty. Without such a cycle, rd_data_o holds its value. This works in either programming method.
- R8: Partial reset rewinds the parallel load pointer, the serial bit position and the readback pointer to the start of the empty offset, and clears rd_data_o to 0. It leaves the offsets and the programming method unchanged. Master reset also clears rd_data_o.
- R9: When master and partial reset are both high, master reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock: offset loading and reset sampling |
| rclk_i | input | 1 | Read clock: offset readback |
| mrst_i | input | 1 | Master reset, active high, synchronous to each clock |
| prst_i | input | 1 | Partial reset, active high, synchronous to each clock |
| ld_i | input | 1 | Load select: picks the default during master reset, marks offset cycles afterwards |
| wen_i | input | 1 | Write enable for parallel loading |
| sen_i | input | 1 | Serial enable for bitwise loading |
| si_i | input | 1 | Serial data bit |
| din_i | input | 18 | Parallel data bus |
| ren_i | input | 1 | Read enable for readback |
| ofs_empty_o | output | 16 | Empty-side offset |
| ofs_full_o | output | 16 | Full-side offset |
| rd_data_o | output | 18 | Readback bus |

## Verification
The embedded properties check a number of things on every clock edge. Master reset loads the right default for the load-select level. A serial cycle flips at most one stored bit. A parallel cycle leaves the bus value in one of the two offsets. Outside load cycles and master reset the offsets stay unchanged, and partial reset leaves both offsets and the method as they were. On the read side, the properties check that the readback bus holds its value, that its upper bits stay zero, and that resets clear it. Some behaviour is visible only in the bench's sweeps, because it depends on a sequence of cycles: the strict empty-then-full alternation and its wrap, the exact bit position of each serial bit, one method ignoring the other method's enable, pointer rewind on partial reset, and master reset taking priority.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;
  typedef enum logic {PROG_PAR = 1'b0, PROG_SER = 1'b1} prog_mode_e;

  function automatic ofs_sel_e next_sel(ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/ofs_wr_ctrl.sv
`timescale 1ns/1ps
module ofs_wr_ctrl
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned DEF_SMALL = 127,
  parameter int unsigned DEF_LARGE = 1023
) (
  input  logic              wclk_i,
  input  logic              mrst_i,
  input  logic              prst_i,
  input  logic              ld_i,
  input  logic              wen_i,
  input  logic              sen_i,
  input  logic              si_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [OFS_W-1:0]  ofs_empty_o,
  output logic [OFS_W-1:0]  ofs_full_o
);
  localparam int unsigned BIT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(OFS_W - 1);
  localparam logic [OFS_W-1:0] SMALL_V = OFS_W'(DEF_SMALL);
  localparam logic [OFS_W-1:0] LARGE_V = OFS_W'(DEF_LARGE);

  prog_mode_e       mode_q;
  ofs_sel_e         ld_ptr_q;
  ofs_sel_e         ser_reg_q;
  logic [BIT_W-1:0] ser_bit_q;
  logic             par_hit, ser_hit;
  logic [OFS_W-1:0] par_word;

  assign par_hit  = ld_i && wen_i && (mode_q == PROG_PAR);
  assign ser_hit  = ld_i && sen_i && (mode_q == PROG_SER);
  assign par_word = din_i[OFS_W-1:0];

  // Sequencing state: method, parallel pointer, serial position
  always_ff @(posedge wclk_i) begin
    if (mrst_i) begin
      mode_q    <= ld_i ? PROG_SER : PROG_PAR;
      ld_ptr_q  <= SEL_EMPTY;
      ser_reg_q <= SEL_EMPTY;
      ser_bit_q <= '0;
    end else if (prst_i) begin
      ld_ptr_q  <= SEL_EMPTY;
      ser_reg_q <= SEL_EMPTY;
      ser_bit_q <= '0;
    end else begin
      if (par_hit) ld_ptr_q <= next_sel(ld_ptr_q);
      if (ser_hit) begin
        if (ser_bit_q == LAST_BIT) begin
          ser_bit_q <= '0;
          ser_reg_q <= next_sel(ser_reg_q);
        end else begin
          ser_bit_q <= ser_bit_q + 1'b1;
        end
      end
    end
  end

  // One storage register per offset
  for (genvar g = 0; g < 2; g++) begin : gen_reg
    logic [OFS_W-1:0] val_q;
    always_ff @(posedge wclk_i) begin
      if (mrst_i) begin
        val_q <= ld_i ? LARGE_V : SMALL_V;
      end else if (!prst_i) begin
        if (par_hit && (ld_ptr_q == ofs_sel_e'(g)))
          val_q <= par_word;
        else if (ser_hit && (ser_reg_q == ofs_sel_e'(g)))
          val_q[ser_bit_q] <= si_i;
      end
    end
  end

  assign ofs_empty_o = gen_reg[0].val_q;
  assign ofs_full_o  = gen_reg[1].val_q;

  // Checks
  assert_mrst_small_R1: assert property (@(posedge wclk_i)
    (mrst_i && !ld_i) |=> (ofs_empty_o == SMALL_V && ofs_full_o == SMALL_V && mode_q == PROG_PAR));
  assert_mrst_large_R2: assert property (@(posedge wclk_i)
    (mrst_i && ld_i) |=> (ofs_empty_o == LARGE_V && ofs_full_o == LARGE_V && mode_q == PROG_SER));
  assert_par_lands_R3: assert property (@(posedge wclk_i) disable iff (mrst_i)
    (par_hit && !prst_i) |=> (ofs_empty_o == $past(par_word) || ofs_full_o == $past(par_word)));
  assert_ser_one_bit_R4: assert property (@(posedge wclk_i) disable iff (mrst_i)
    (ser_hit && !prst_i) |=> ($countones({ofs_empty_o, ofs_full_o} ^ $past({ofs_empty_o, ofs_full_o})) <= 1));
  assert_idle_hold_R6: assert property (@(posedge wclk_i) disable iff (mrst_i)
    !(ld_i && (wen_i || sen_i)) |=> ($stable(ofs_empty_o) && $stable(ofs_full_o)));
  assert_prst_keep_R8: assert property (@(posedge wclk_i) disable iff (mrst_i)
    prst_i |=> ($stable(ofs_empty_o) && $stable(ofs_full_o) && $stable(mode_q)));
endmodule

// File: rtl/ofs_rd_port.sv
`timescale 1ns/1ps
module ofs_rd_port
  import ofs_pkg::*;
#(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned DATA_W = 18
) (
  input  logic              rclk_i,
  input  logic              mrst_i,
  input  logic              prst_i,
  input  logic              ld_i,
  input  logic              ren_i,
  input  logic [OFS_W-1:0]  ofs_empty_i,
  input  logic [OFS_W-1:0]  ofs_full_i,
  output logic [DATA_W-1:0] rd_data_o
);
  ofs_sel_e         rd_ptr_q;
  logic             rd_hit;
  logic [OFS_W-1:0] rd_pick;

  assign rd_hit  = ld_i && ren_i;
  assign rd_pick = (rd_ptr_q == SEL_EMPTY) ? ofs_empty_i : ofs_full_i;

  always_ff @(posedge rclk_i) begin
    if (mrst_i || prst_i) begin
      rd_ptr_q  <= SEL_EMPTY;
      rd_data_o <= '0;
    end else if (rd_hit) begin
      rd_ptr_q  <= next_sel(rd_ptr_q);
      rd_data_o <= DATA_W'(rd_pick);
    end
  end

  // Checks
  assert_rd_hold_R7: assert property (@(posedge rclk_i) disable iff (mrst_i)
    (!rd_hit && !prst_i) |=> $stable(rd_data_o));
  assert_rd_source_R7: assert property (@(posedge rclk_i) disable iff (mrst_i)
    (rd_hit && !prst_i) |=> (rd_data_o[OFS_W-1:0] == $past(ofs_empty_i) ||
                             rd_data_o[OFS_W-1:0] == $past(ofs_full_i)));
  assert_rd_reset_R8: assert property (@(posedge rclk_i)
    (mrst_i || prst_i) |=> (rd_data_o == '0));
  if (DATA_W > OFS_W) begin : gen_upper_chk
    assert_rd_upper_zero_R7: assert property (@(posedge rclk_i) disable iff (mrst_i)
      (rd_data_o[DATA_W-1:OFS_W] == '0));
  end
endmodule

// File: rtl/ofs_regfile.sv
`timescale 1ns/1ps
module ofs_regfile #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned DEF_SMALL = 127,
  parameter int unsigned DEF_LARGE = 1023
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              mrst_i,
  input  logic              prst_i,
  input  logic              ld_i,
  input  logic              wen_i,
  input  logic              sen_i,
  input  logic              si_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ren_i,
  output logic [OFS_W-1:0]  ofs_empty_o,
  output logic [OFS_W-1:0]  ofs_full_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [OFS_W-1:0] empty_w, full_w;

  ofs_wr_ctrl #(
    .OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_SMALL(DEF_SMALL), .DEF_LARGE(DEF_LARGE)
  ) u_wr (
    .wclk_i(wclk_i), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
    .wen_i(wen_i), .sen_i(sen_i), .si_i(si_i), .din_i(din_i),
    .ofs_empty_o(empty_w), .ofs_full_o(full_w)
  );

  ofs_rd_port #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
    .rclk_i(rclk_i), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
    .ren_i(ren_i), .ofs_empty_i(empty_w), .ofs_full_i(full_w),
    .rd_data_o(rd_data_o)
  );

  assign ofs_empty_o = empty_w;
  assign ofs_full_o  = full_w;
endmodule

// File: tb/ofs_regfile_bench.sv
`timescale 1ns/1ps
module ofs_regfile_bench;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        mrst = 1'b1, prst = 1'b0, ld = 1'b0;
  logic        wen = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0;
  logic [17:0] din = '0;
  logic [15:0] ofs_e, ofs_f;
  logic [17:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_e, exp_f;
  int wptr = 0, sreg = 0, sbit = 0, rptr = 0;

  ofs_regfile u_ofs_regfile (
    .wclk_i(wclk), .rclk_i(rclk), .mrst_i(mrst), .prst_i(prst), .ld_i(ld),
    .wen_i(wen), .sen_i(sen), .si_i(si), .din_i(din), .ren_i(ren),
    .ofs_empty_o(ofs_e), .ofs_full_o(ofs_f), .rd_data_o(rd_data)
  );

  always #5 wclk = ~wclk;
  initial begin #2; forever #5 rclk = ~rclk; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write edge and one read edge, returns at the following falling write edge
  task automatic cyc();
    @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic idle();
    wen = 0; sen = 0; ren = 0; ld = 0; si = 0; mrst = 0; prst = 0;
  endtask

  task automatic do_mrst(logic sel, logic with_prst);
    mrst = 1; prst = with_prst; ld = sel; cyc(); idle();
    exp_e = sel ? 16'd1023 : 16'd127; exp_f = exp_e;
    wptr = 0; sreg = 0; sbit = 0; rptr = 0;
  endtask

  task automatic ppush(logic [17:0] v, logic active);
    wen = 1; ld = 1; din = v; cyc(); idle();
    if (active) begin
      if (wptr == 0) exp_e = v[15:0]; else exp_f = v[15:0];
      wptr ^= 1;
    end
  endtask

  task automatic spush(logic b, logic active);
    sen = 1; ld = 1; si = b; cyc(); idle();
    if (active) begin
      if (sreg == 0) exp_e[sbit] = b; else exp_f[sbit] = b;
      sbit++;
      if (sbit == 16) begin sbit = 0; sreg ^= 1; end
    end
  endtask

  task automatic rdcheck(string req);
    ren = 1; ld = 1; cyc(); idle();
    chk(req, 32'(rd_data), 32'({2'b00, (rptr == 0) ? exp_e : exp_f}));
    rptr ^= 1;
  endtask

  task automatic chk_ofs(string req);
    chk(req, 32'(ofs_e), 32'(exp_e));
    chk(req, 32'(ofs_f), 32'(exp_f));
  endtask

  initial begin
    logic [15:0] v;
    cyc();
    do_mrst(1'b0, 1'b0);
    chk_ofs("R1 default small");
    chk("R8 rd cleared", 32'(rd_data), 0);
    rdcheck("R7 readback empty"); rdcheck("R7 readback full");

    // R3 parallel sweep, upper bus bits set to show they are discarded
    for (int i = 0; i < 40; i++) begin
      v = 16'((i * 16'h2F1B + 16'h0101) ^ (i << 9));
      if (i == 5) v = 16'h0000;
      if (i == 6) v = 16'hFFFF;
      ppush({2'b11, v}, 1'b1);
      chk_ofs("R3 parallel load");
    end
    for (int i = 0; i < 4; i++) rdcheck("R7 readback alternation");

    // R5 serial enable ignored in parallel mode
    for (int i = 0; i < 5; i++) spush(1'b1, 1'b0);
    chk_ofs("R5 serial ignored");
    // R6 write enable without load select
    wen = 1; din = 18'h0A5A5; cyc(); cyc(); idle();
    chk_ofs("R6 no load without ld");

    // R8 partial reset rewinds pointers, keeps values
    ppush(18'h01111, 1'b1);
    rdcheck("R7 readback before prst");
    prst = 1; cyc(); idle();
    wptr = 0; rptr = 0;
    chk_ofs("R8 values kept");
    chk("R8 rd cleared by prst", 32'(rd_data), 0);
    ppush(18'h02222, 1'b1);
    chk_ofs("R8 load pointer rewound");
    rdcheck("R8 read pointer rewound");

    // R9 master beats partial
    do_mrst(1'b0, 1'b1);
    chk_ofs("R9 master over partial");

    // R2 large default, serial method
    do_mrst(1'b1, 1'b0);
    chk_ofs("R2 default large");
    for (int w = 0; w < 3; w++) begin
      v = 16'(16'hC35A + w * 16'h1357);
      for (int b = 0; b < 16; b++) begin
        spush(v[b], 1'b1);
        chk_ofs("R4 serial bit");
      end
    end
    rdcheck("R7 readback serial empty"); rdcheck("R7 readback serial full");

    // R5 parallel ignored in serial mode
    ppush(18'h3BEEF, 1'b0);
    chk_ofs("R5 parallel ignored");

    // R8 partial reset mid-word in serial mode
    for (int b = 0; b < 5; b++) spush(1'b0, 1'b1);
    prst = 1; cyc(); idle();
    sreg = 0; sbit = 0; rptr = 0;
    chk_ofs("R8 serial values kept");
    v = 16'h9A6D;
    for (int b = 0; b < 16; b++) spush(v[b], 1'b1);
    chk("R8 serial restart empty", 32'(ofs_e), 32'(v));
    chk_ofs("R8 serial restart");
    rdcheck("R8 readback after serial prst");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule